// File: doc/BRIEF.md
# Write-Steering Hybrid Cache Way Controller

This block holds the tags and the placement policy for one set-associative cache bank in which every set combines twelve ways built from a dense technology with slow writes and one way built from a technology with fast writes. It accepts one read or write request at a time through a valid/ready handshake, decides hit or miss, chooses where a missing line goes, and keeps lines that are written back-to-back out of the slow-write ways by promoting them into the fast-write way. The data cells themselves are not part of the block.

Each access is held for a number of cycles that models the array timing of the way it touches: reads cost the same in both technologies, writes cost far more in the slow ways. When the access is done, a single-cycle response reports hit or miss, the way that served it and the cycle count spent in the array. Refills and writebacks of 64-byte lines go to the next memory level through a simple request/response port; a dirty victim is written back before the refill is requested.

Each slow-way line carries one bit recording that its most recent access was a write. A second write in a row moves the line to the fast way, and whatever the fast way held moves into the freed slow way with its dirty state intact, so no line ever travels between two slow ways and a promotion never causes memory traffic.

Top module: `hwc_ctrl`

## Requirements
- R1: A set has slow ways numbered 0 to 11 and the fast way numbered 12; the response reports the number of the way that served the access.
- R2: req_ready is high only while idle; it falls after an accepted request and stays low until the cycle after the single-cycle rsp_valid pulse.
- R3: A read hit in either way type reports 10 array cycles, raises rsp_valid 11 cycles after the acceptance edge and issues no memory request.
- R4: A write hit in the fast way reports 10 cycles; a write hit in a slow way whose write flag is clear reports 33 cycles, marks the line dirty and sets its write flag.
- R5: A write hit in a slow way whose write flag is set moves the line into way 12 (reported as the served way) in 10+10 cycles, plus 33 when way 12 held a valid line; that line is placed in the freed slow way with its dirty state kept, and no memory request is made.
- R6: A read hit on a slow line clears its write flag, so the next write to it is a plain 33-cycle slow write.
- R7: A write miss is placed in way 12 unless way 12 holds a valid dirty line, in which case it goes to a slow way chosen as in R8 and sets that line's write flag.
- R8: A read miss, or a write miss refused by way 12, uses the lowest-numbered invalid slow way, else the least recently used slow way of the set; a read miss never fills way 12.
- R9: A miss reports rsp_hit=0 and issues one refill (mem_req_write=0, line address with the six offset bits zero); a valid dirty victim first causes one writeback (mem_req_write=1, the victim's line address). The reported cycles are 10 when a dirty victim was read out, plus 10 for a fast-way or 33 for a slow-way fill.
- R10: A memory request keeps its address and direction stable until mem_req_ready is seen.
- R11: After reset every way is invalid, req_ready is high, and rsp_valid and mem_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_hit | output | 1 | 1 when the access hit |
| rsp_way | output | WAY_W | Way that served the access |
| rsp_cycles | output | CYC_W | Array cycles spent on the access |
| mem_req_valid | output | 1 | Next-level request offered |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_write | output | 1 | 1 for a writeback, 0 for a refill |
| mem_req_addr | output | ADDR_W | Line address of the transfer |
| mem_rsp_valid | input | 1 | Next level has completed the transfer |

## Verification
The two functions that fall into one cycle are the promotion of a repeatedly written slow line into way 12 and the demotion of the previous way-12 line into the slow way being vacated; both tag-store writes land on the same clock edge. The bench provokes this by writing a line into a slow way while way 12 already holds a dirty line, then writing it again, and judges it by the 53-cycle response naming way 12 with no memory traffic, a 10-cycle read hit on the old way-12 line in the vacated slow way, and a later eviction of that way that produces a writeback of the demoted line ahead of its refill.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_WB_REQ,
      ST_WB_WAIT,
      ST_FILL_REQ,
      ST_FILL_WAIT,
      ST_BUSY,
      ST_RESP
   } hwc_state_e;

   // array cycles for a miss: optional victim read-out plus the fill write
   function automatic int unsigned hwc_miss_cycles(input bit victim_dirty, input bit to_fast,
                                                   input int unsigned rd, input int unsigned fw,
                                                   input int unsigned sw);
      return (victim_dirty ? rd : 0) + (to_fast ? fw : sw);
   endfunction

endpackage

// File: rtl/hwc_tag_store.sv
module hwc_tag_store #(
   parameter int NUM_SETS = 16,
   parameter int WAYS     = 13,
   parameter int TAG_W    = 22,
   parameter int SET_W    = 4,
   parameter int WAY_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way,
   output logic [WAYS-1:0]  way_valid,
   output logic [WAYS-1:0]  way_dirty,
   output logic [WAYS-1:0]  way_wflag,
   output logic [TAG_W-1:0] way_tag [WAYS],
   output logic             free_found,
   output logic [WAY_W-1:0] free_way,
   input  logic             wa_en,
   input  logic [WAY_W-1:0] wa_way,
   input  logic             wa_valid,
   input  logic             wa_dirty,
   input  logic             wa_wflag,
   input  logic [TAG_W-1:0] wa_tag,
   input  logic             wb_en,
   input  logic [WAY_W-1:0] wb_way,
   input  logic             wb_valid,
   input  logic             wb_dirty,
   input  logic             wb_wflag,
   input  logic [TAG_W-1:0] wb_tag
);

   logic [WAYS-1:0]  valid_q [NUM_SETS];
   logic [WAYS-1:0]  dirty_q [NUM_SETS];
   logic [WAYS-1:0]  wflag_q [NUM_SETS];
   logic [TAG_W-1:0] tag_q   [NUM_SETS][WAYS];
   logic [WAYS-1:0]  hit_vec;

   assign way_valid = valid_q[rd_set];
   assign way_dirty = dirty_q[rd_set];
   assign way_wflag = wflag_q[rd_set];

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign way_tag[g] = tag_q[rd_set][g];
      assign hit_vec[g] = valid_q[rd_set][g] && (tag_q[rd_set][g] == rd_tag);
   end

   always_comb begin
      hit     = |hit_vec;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   // lowest-numbered invalid slow way (the last way is the fast one)
   always_comb begin
      free_found = 1'b0;
      free_way   = '0;
      for (int w = WAYS - 2; w >= 0; w--) begin
         if (!valid_q[rd_set][w]) begin
            free_found = 1'b1;
            free_way   = WAY_W'(w);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
            wflag_q[s] <= '0;
         end
      end else begin
         if (wa_en) begin
            valid_q[rd_set][wa_way] <= wa_valid;
            dirty_q[rd_set][wa_way] <= wa_dirty;
            wflag_q[rd_set][wa_way] <= wa_wflag;
         end
         if (wb_en) begin
            valid_q[rd_set][wb_way] <= wb_valid;
            dirty_q[rd_set][wb_way] <= wb_dirty;
            wflag_q[rd_set][wb_way] <= wb_wflag;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wa_en) tag_q[rd_set][wa_way] <= wa_tag;
      if (wb_en) tag_q[rd_set][wb_way] <= wb_tag;
   end

endmodule

// File: rtl/hwc_lru.sv
module hwc_lru #(
   parameter int NUM_SETS  = 16,
   parameter int SLOW_WAYS = 12,
   parameter int SET_W     = 4,
   parameter int SW_W      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [SW_W-1:0]  victim,
   input  logic             touch_en,
   input  logic [SW_W-1:0]  touch_way
);

   // rank 0 = most recently used, SLOW_WAYS-1 = least recently used
   logic [SW_W-1:0] rank_q [NUM_SETS][SLOW_WAYS];

   always_comb begin
      victim = '0;
      for (int w = 0; w < SLOW_WAYS; w++) begin
         if (rank_q[rd_set][w] == SW_W'(SLOW_WAYS - 1)) victim = SW_W'(w);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            for (int w = 0; w < SLOW_WAYS; w++) begin
               rank_q[s][w] <= SW_W'(w);
            end
         end
      end else if (touch_en) begin
         for (int w = 0; w < SLOW_WAYS; w++) begin
            if (SW_W'(w) == touch_way) begin
               rank_q[rd_set][w] <= '0;
            end else if (rank_q[rd_set][w] < rank_q[rd_set][touch_way]) begin
               rank_q[rd_set][w] <= rank_q[rd_set][w] + SW_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/hwc_lat_timer.sv
module hwc_lat_timer #(
   parameter int CYC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CYC_W-1:0] target,
   output logic             done,
   output logic [CYC_W-1:0] count
);

   logic             running_q;
   logic [CYC_W-1:0] count_q;
   logic [CYC_W-1:0] target_q;

   assign done  = running_q && ((count_q + CYC_W'(1)) == target_q);
   assign count = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         count_q   <= '0;
         target_q  <= '0;
      end else if (start) begin
         running_q <= 1'b1;
         count_q   <= '0;
         target_q  <= target;
      end else if (running_q) begin
         count_q <= count_q + CYC_W'(1);
         if (done) running_q <= 1'b0;
      end
   end

endmodule

// File: rtl/hwc_ctrl.sv
module hwc_ctrl #(
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 64,
   parameter int NUM_SETS    = 16,
   parameter int SLOW_WAYS   = 12,
   parameter int RD_LAT      = 10,
   parameter int FAST_WR_LAT = 10,
   parameter int SLOW_WR_LAT = 33,
   localparam int WAYS       = SLOW_WAYS + 1,
   localparam int WAY_W      = $clog2(WAYS),
   localparam int MAX_LAT    = RD_LAT + FAST_WR_LAT + SLOW_WR_LAT,
   localparam int CYC_W      = $clog2(MAX_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [CYC_W-1:0]  rsp_cycles,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid
);
   import hwc_pkg::*;

   localparam int OFF_W    = $clog2(LINE_BYTES);
   localparam int SET_W    = $clog2(NUM_SETS);
   localparam int TAG_W    = ADDR_W - OFF_W - SET_W;
   localparam int SW_W     = $clog2(SLOW_WAYS);
   localparam int FAST_WAY = SLOW_WAYS;

   if (NUM_SETS < 2 || (1 << SET_W) != NUM_SETS) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (SLOW_WAYS < 2) begin : g_bad_ways
      $error("SLOW_WAYS must be at least 2");
   end
   if (RD_LAT < 1 || FAST_WR_LAT < 1 || SLOW_WR_LAT < 1) begin : g_bad_lat
      $error("latencies must be at least one cycle");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the set and offset fields");
   end

   hwc_state_e        state_q, state_d;
   logic              wr_q;
   logic [TAG_W-1:0]  rtag_q;
   logic [SET_W-1:0]  set_q;
   logic [CYC_W-1:0]  lat_q, lat_d;
   logic              rsp_hit_q;
   logic [WAY_W-1:0]  rsp_way_q, rsp_way_d;
   logic [TAG_W-1:0]  wb_tag_q, wb_tag_d;
   logic              unused_off;

   assign unused_off = ^req_addr[OFF_W-1:0];

   // tag store signals
   logic              hit;
   logic [WAY_W-1:0]  hit_way;
   logic [WAYS-1:0]   way_valid, way_dirty, way_wflag;
   logic [TAG_W-1:0]  way_tag [WAYS];
   logic              free_found;
   logic [WAY_W-1:0]  free_way;
   logic              wa_en, wa_valid, wa_dirty, wa_wflag;
   logic [WAY_W-1:0]  wa_way;
   logic [TAG_W-1:0]  wa_tag;
   logic              wb_en, wb_valid, wb_dirty, wb_wflag;
   logic [WAY_W-1:0]  wb_way;
   logic [TAG_W-1:0]  wb_tag;

   // replacement and timing signals
   logic [SW_W-1:0]   lru_victim;
   logic              touch_en;
   logic [SW_W-1:0]   touch_way;
   logic              tmr_start, tmr_done;
   logic [CYC_W-1:0]  tmr_target, tmr_count;

   // lookup decision signals
   logic              fast_valid, fast_dirty, to_fast, vic_dirty;
   logic [WAY_W-1:0]  tgt_way;

   hwc_tag_store #(
      .NUM_SETS (NUM_SETS),
      .WAYS     (WAYS),
      .TAG_W    (TAG_W),
      .SET_W    (SET_W),
      .WAY_W    (WAY_W)
   ) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_set     (set_q),
      .rd_tag     (rtag_q),
      .hit        (hit),
      .hit_way    (hit_way),
      .way_valid  (way_valid),
      .way_dirty  (way_dirty),
      .way_wflag  (way_wflag),
      .way_tag    (way_tag),
      .free_found (free_found),
      .free_way   (free_way),
      .wa_en      (wa_en),
      .wa_way     (wa_way),
      .wa_valid   (wa_valid),
      .wa_dirty   (wa_dirty),
      .wa_wflag   (wa_wflag),
      .wa_tag     (wa_tag),
      .wb_en      (wb_en),
      .wb_way     (wb_way),
      .wb_valid   (wb_valid),
      .wb_dirty   (wb_dirty),
      .wb_wflag   (wb_wflag),
      .wb_tag     (wb_tag)
   );

   hwc_lru #(
      .NUM_SETS  (NUM_SETS),
      .SLOW_WAYS (SLOW_WAYS),
      .SET_W     (SET_W),
      .SW_W      (SW_W)
   ) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_set    (set_q),
      .victim    (lru_victim),
      .touch_en  (touch_en),
      .touch_way (touch_way)
   );

   hwc_lat_timer #(
      .CYC_W (CYC_W)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start),
      .target (tmr_target),
      .done   (tmr_done),
      .count  (tmr_count)
   );

   assign fast_valid = way_valid[FAST_WAY];
   assign fast_dirty = way_dirty[FAST_WAY];
   assign to_fast    = wr_q && !(fast_valid && fast_dirty);
   assign tgt_way    = to_fast ? WAY_W'(FAST_WAY)
                     : (free_found ? free_way : WAY_W'(lru_victim));
   assign vic_dirty  = way_valid[tgt_way] && way_dirty[tgt_way];

   // lookup: all tag-state updates of one request happen on one edge
   always_comb begin
      wa_en     = 1'b0;
      wa_way    = '0;
      wa_valid  = 1'b1;
      wa_dirty  = 1'b0;
      wa_wflag  = 1'b0;
      wa_tag    = rtag_q;
      wb_en     = 1'b0;
      wb_way    = '0;
      wb_valid  = 1'b0;
      wb_dirty  = 1'b0;
      wb_wflag  = 1'b0;
      wb_tag    = way_tag[FAST_WAY];
      touch_en  = 1'b0;
      touch_way = SW_W'(hit_way);
      lat_d     = lat_q;
      rsp_way_d = hit_way;
      wb_tag_d  = wb_tag_q;
      if (state_q == ST_LOOKUP) begin
         if (hit && hit_way == WAY_W'(FAST_WAY)) begin
            lat_d    = wr_q ? CYC_W'(FAST_WR_LAT) : CYC_W'(RD_LAT);
            wa_en    = wr_q;
            wa_way   = hit_way;
            wa_dirty = 1'b1;
         end else if (hit && !wr_q) begin
            lat_d    = CYC_W'(RD_LAT);
            wa_en    = 1'b1;
            wa_way   = hit_way;
            wa_dirty = way_dirty[hit_way];
            touch_en = 1'b1;
         end else if (hit && way_wflag[hit_way]) begin
            // second write in a row: promote, demote the fast line into the gap
            lat_d     = CYC_W'(RD_LAT) + CYC_W'(FAST_WR_LAT)
                      + (fast_valid ? CYC_W'(SLOW_WR_LAT) : CYC_W'(0));
            wa_en     = 1'b1;
            wa_way    = WAY_W'(FAST_WAY);
            wa_dirty  = 1'b1;
            wb_en     = 1'b1;
            wb_way    = hit_way;
            wb_valid  = fast_valid;
            wb_dirty  = fast_dirty;
            touch_en  = 1'b1;
            rsp_way_d = WAY_W'(FAST_WAY);
         end else if (hit) begin
            lat_d    = CYC_W'(SLOW_WR_LAT);
            wa_en    = 1'b1;
            wa_way   = hit_way;
            wa_dirty = 1'b1;
            wa_wflag = 1'b1;
            touch_en = 1'b1;
         end else begin
            lat_d     = CYC_W'(hwc_miss_cycles(vic_dirty, to_fast, RD_LAT,
                                               FAST_WR_LAT, SLOW_WR_LAT));
            wa_en     = 1'b1;
            wa_way    = tgt_way;
            wa_dirty  = wr_q;
            wa_wflag  = wr_q && !to_fast;
            touch_en  = !to_fast;
            touch_way = SW_W'(tgt_way);
            rsp_way_d = tgt_way;
            wb_tag_d  = way_tag[tgt_way];
         end
      end
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:      if (req_valid) state_d = ST_LOOKUP;
         ST_LOOKUP:    state_d = hit ? ST_BUSY : (vic_dirty ? ST_WB_REQ : ST_FILL_REQ);
         ST_WB_REQ:    if (mem_req_ready) state_d = ST_WB_WAIT;
         ST_WB_WAIT:   if (mem_rsp_valid) state_d = ST_FILL_REQ;
         ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_WAIT;
         ST_FILL_WAIT: if (mem_rsp_valid) state_d = ST_BUSY;
         ST_BUSY:      if (tmr_done) state_d = ST_RESP;
         ST_RESP:      state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   assign tmr_start  = (state_q == ST_LOOKUP && hit) || (state_q == ST_FILL_WAIT && mem_rsp_valid);
   assign tmr_target = (state_q == ST_LOOKUP) ? lat_d : lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         wr_q      <= 1'b0;
         rtag_q    <= '0;
         set_q     <= '0;
         lat_q     <= '0;
         rsp_hit_q <= 1'b0;
         rsp_way_q <= '0;
         wb_tag_q  <= '0;
      end else begin
         state_q  <= state_d;
         lat_q    <= lat_d;
         wb_tag_q <= wb_tag_d;
         if (state_q == ST_IDLE && req_valid) begin
            wr_q   <= req_write;
            rtag_q <= req_addr[ADDR_W-1 -: TAG_W];
            set_q  <= req_addr[OFF_W +: SET_W];
         end
         if (state_q == ST_LOOKUP) begin
            rsp_hit_q <= hit;
            rsp_way_q <= rsp_way_d;
         end
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign rsp_valid     = (state_q == ST_RESP);
   assign rsp_hit       = rsp_hit_q;
   assign rsp_way       = rsp_way_q;
   assign rsp_cycles    = tmr_count;
   assign mem_req_valid = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
   assign mem_req_write = (state_q == ST_WB_REQ);
   assign mem_req_addr  = (state_q == ST_WB_REQ) ? {wb_tag_q, set_q, OFF_W'(0)}
                                                 : {rtag_q, set_q, OFF_W'(0)};

endmodule

// File: rtl/hwc_ctrl_chk.sv
module hwc_ctrl_chk #(
   parameter int ADDR_W      = 32,
   parameter int WAY_W       = 4,
   parameter int CYC_W       = 6,
   parameter int FAST_WAY    = 12,
   parameter int RD_LAT      = 10,
   parameter int FAST_WR_LAT = 10,
   parameter int SLOW_WR_LAT = 33
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [WAY_W-1:0]  rsp_way,
   input logic [CYC_W-1:0]  rsp_cycles,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr
);

   logic wr_seen_q;
   logic mem_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_seen_q  <= 1'b0;
         mem_seen_q <= 1'b0;
      end else if (req_valid && req_ready) begin
         wr_seen_q  <= req_write;
         mem_seen_q <= 1'b0;
      end else if (mem_req_valid && mem_req_ready) begin
         mem_seen_q <= 1'b1;
      end
   end

   p_way_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (int'(rsp_way) <= FAST_WAY));

   p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_busy_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   p_accept_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_read_hit_cycles_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && !wr_seen_q) |-> (int'(rsp_cycles) == RD_LAT));

   p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> !mem_seen_q);

   p_slow_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && wr_seen_q && int'(rsp_way) != FAST_WAY)
      |-> (int'(rsp_cycles) == SLOW_WR_LAT));

   p_fast_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && wr_seen_q && int'(rsp_way) == FAST_WAY)
      |-> (int'(rsp_cycles) == FAST_WR_LAT || int'(rsp_cycles) == RD_LAT + FAST_WR_LAT
           || int'(rsp_cycles) == RD_LAT + FAST_WR_LAT + SLOW_WR_LAT));

   p_miss_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> mem_seen_q);

   p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready)
      |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

endmodule

bind hwc_ctrl hwc_ctrl_chk #(
   .ADDR_W      (ADDR_W),
   .WAY_W       (WAY_W),
   .CYC_W       (CYC_W),
   .FAST_WAY    (SLOW_WAYS),
   .RD_LAT      (RD_LAT),
   .FAST_WR_LAT (FAST_WR_LAT),
   .SLOW_WR_LAT (SLOW_WR_LAT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_write     (req_write),
   .rsp_valid     (rsp_valid),
   .rsp_hit       (rsp_hit),
   .rsp_way       (rsp_way),
   .rsp_cycles    (rsp_cycles),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr)
);

// File: tb/hwc_ctrl_tb_top.sv
module hwc_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic        req_write;
   logic [31:0] req_addr;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [3:0]  rsp_way;
   logic [5:0]  rsp_cycles;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic        mem_req_write;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;

   int          n_chk = 0;
   int          n_fail = 0;
   int          mem_n = 0;
   int          last_m0 = 0;
   logic        mlog_wr   [16];
   logic [31:0] mlog_addr [16];

   always #2 clk = ~clk;

   hwc_ctrl dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_write     (req_write),
      .req_addr      (req_addr),
      .rsp_valid     (rsp_valid),
      .rsp_hit       (rsp_hit),
      .rsp_way       (rsp_way),
      .rsp_cycles    (rsp_cycles),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid)
   );

   function automatic logic [31:0] mk(input int tag, input int set, input int off);
      return 32'((tag << 10) | (set << 6) | off);
   endfunction

   task automatic chkeq(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic chk_mem(input int k, input int ewr, input logic [31:0] eaddr, input string rq);
      chkeq(rq, int'(mlog_wr[k % 16]), ewr);
      n_chk++;
      if (mlog_addr[k % 16] != eaddr) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, mlog_addr[k % 16], eaddr);
      end
   endtask

   // next-level memory: accepts at the first negedge a request is seen, completes 4 cycles later
   initial begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            mem_req_ready = 1'b1;
            mlog_wr[mem_n % 16]   = mem_req_write;
            mlog_addr[mem_n % 16] = mem_req_addr;
            mem_n++;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (3) @(negedge clk);
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   task automatic do_acc(input bit wr, input int tag, input int set, input int off,
                         input int ehit, input int eway, input int ecyc, input int enmem,
                         input string rq);
      int edges;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      last_m0   = mem_n;
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = mk(tag, set, off);
      @(posedge clk);
      #1 req_valid = 1'b0;
      edges = 0;
      do begin
         @(posedge clk);
         #1 edges++;
      end while (!rsp_valid && edges < 3000);
      chkeq(rq, int'(rsp_hit), ehit);
      chkeq(rq, int'(rsp_way), eway);
      chkeq(rq, int'(rsp_cycles), ecyc);
      chkeq(rq, mem_n - last_m0, enmem);
      if (ehit != 0) chkeq("R3 timing", edges, ecyc + 1);
      chkeq("R2", int'(req_ready), 0);
      @(posedge clk);
      #1 chkeq("R2", int'(req_ready), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr  = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chkeq("R11", int'(req_ready), 1);
      chkeq("R11", int'(rsp_valid), 0);
      chkeq("R11", int'(mem_req_valid), 0);

      // sweep every set: fill the slow ways in order, then read each back
      for (int s = 0; s < 16; s++) begin
         for (int i = 0; i < 12; i++) begin
            do_acc(1'b0, i + 1, s, 7, 0, i, 33, 1, "R8");
            chk_mem(last_m0, 0, mk(i + 1, s, 0), "R10");
         end
         for (int i = 0; i < 12; i++) begin
            do_acc(1'b0, i + 1, s, 5, 1, i, 10, 0, "R3");
         end
      end

      // set 1: first write sets the flag, second write promotes into an empty fast way
      do_acc(1'b1, 3, 1, 0, 1, 2, 33, 0, "R4");
      do_acc(1'b1, 3, 1, 0, 1, 12, 20, 0, "R5");
      do_acc(1'b0, 3, 1, 0, 1, 12, 10, 0, "R1");
      // freed way 2 is the lowest invalid slow way
      do_acc(1'b0, 50, 1, 0, 0, 2, 33, 1, "R8");
      do_acc(1'b1, 3, 1, 0, 1, 12, 10, 0, "R4");
      // fast way dirty: write miss goes to the LRU slow way (way 0, clean)
      do_acc(1'b1, 60, 1, 0, 0, 0, 33, 1, "R7");
      chk_mem(last_m0, 0, mk(60, 1, 0), "R9");
      // second write: swap with the occupied fast way
      do_acc(1'b1, 60, 1, 0, 1, 12, 53, 0, "R5");
      do_acc(1'b0, 3, 1, 0, 1, 0, 10, 0, "R5");
      do_acc(1'b0, 60, 1, 0, 1, 12, 10, 0, "R5");
      // age way 0 to LRU, then evict it: the demoted line is still dirty
      do_acc(1'b0, 2, 1, 0, 1, 1, 10, 0, "R8");
      do_acc(1'b0, 50, 1, 0, 1, 2, 10, 0, "R8");
      for (int w = 3; w < 12; w++) begin
         do_acc(1'b0, w + 1, 1, 0, 1, w, 10, 0, "R8");
      end
      do_acc(1'b0, 99, 1, 42, 0, 0, 43, 2, "R9");
      chk_mem(last_m0, 1, mk(3, 1, 0), "R9");
      chk_mem(last_m0 + 1, 0, mk(99, 1, 0), "R9");

      // set 3: a read between writes clears the flag
      do_acc(1'b1, 5, 3, 0, 1, 4, 33, 0, "R4");
      do_acc(1'b0, 5, 3, 0, 1, 4, 10, 0, "R6");
      do_acc(1'b1, 5, 3, 0, 1, 4, 33, 0, "R6");

      // set 4: write miss with an empty fast way lands in way 12
      do_acc(1'b1, 80, 4, 0, 0, 12, 10, 1, "R7");
      chk_mem(last_m0, 0, mk(80, 4, 0), "R7");

      // set 5: read miss with an empty fast way still uses the LRU slow way
      do_acc(1'b0, 90, 5, 0, 0, 0, 33, 1, "R8");

      // set 6: touching way 0 makes way 1 the victim
      do_acc(1'b0, 1, 6, 0, 1, 0, 10, 0, "R8");
      do_acc(1'b0, 91, 6, 0, 0, 1, 33, 1, "R8");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule